// File: doc/BRIEF.md
# Two-Channel ADC Trigger Tagger

This block sits in the sample path of a two-channel acquisition front end. Every cycle that a pair of 12-bit two's-complement samples is presented, it decides for each channel whether a capture trigger has occurred. The decision is written into the four spare upper bits of that channel's 16-bit output word, one register stage later, so the flag travels with its sample through any downstream pipeline of unknown depth. A trigger can come from the sample value measured against a programmable limit, from an external digital pin, or from a combination of the two.

Configuration is written through a small register port clocked by a bus clock that is unrelated to the ADC clock. Each register is carried across to the ADC domain as a whole, with a toggle handshake, so that the sample path never sees a mix of old and new fields. The same control registers can also make the block drive the trigger pins as outputs.

Register map (address on `cfg_addr`): 0 is channel A control, 1 is channel B control, 2 is channel A level, 3 is channel B level. Control layout: bits [2:0] pin mode, [5:3] analog mode, [7:6] source select, [8] pin drive enable, [9] pin drive value. Level layout: bits [11:0] limit (two's complement), [23:12] hysteresis (unsigned).

Top module: `adc_trig_tagger`

## Requirements
- R1: While `adc_rst_n` is low, `out_valid` is 0, both output words are 0 and `trig_pin_oe` is 0.
- R2: A sample pair presented with `adc_valid` high appears one ADC clock later with `out_valid` high and the sample in bits [11:0] of `out_a` / `out_b`.
- R3: Analog mode 0 reports a hit when the sample is greater than the limit and mode 1 when it is less than the limit, both compared as signed 12-bit values.
- R4: Analog mode 3 hits on an upward crossing (previous sample at or below the limit, current above it), mode 4 on a downward crossing (previous at or above, current below), mode 2 on either; the previous sample is the last valid one, 0 after reset.
- R5: After an upward crossing is reported, the next upward crossing is accepted only after a sample at or below limit minus hysteresis; after a downward crossing, only after a sample at or above limit plus hysteresis; both are armed after reset.
- R6: Pin mode 0 hits when the synchronized pin is high, mode 1 when low, mode 3 on a rising edge, mode 4 on a falling edge, mode 2 on either edge, where an edge counts if it occurred since the previous valid sample.
- R7: Pin input bit 0 feeds channel A and bit 1 feeds channel B.
- R8: Source select 0 uses the analog hit, 1 the pin hit, 2 their AND, 3 their OR; the channel A flag is bit 15 and the channel B flag is bit 14 of both output words, bit 13 holds the word's own analog hit and bit 12 its own pin hit.
- R9: Analog and pin mode codes 5 to 7 never hit; after reset both control registers hold 0x03F, so no trigger is reported.
- R10: A register written on the configuration port takes effect for samples presented a few ADC clocks later, all of its fields at once.
- R11: `trig_pin_oe[c]` and `trig_pin_o[c]` follow the drive enable and drive value bits of channel c's control register.
- R12: In a cycle where `out_valid` is 0 both output words are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cfg_clk | input | 1 | Configuration bus clock |
| cfg_rst_n | input | 1 | Active-low reset, bus domain |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register address |
| cfg_wdata | input | 24 | Register write data |
| adc_clk | input | 1 | Sample clock |
| adc_rst_n | input | 1 | Active-low reset, sample domain |
| adc_valid | input | 1 | Sample pair valid |
| adc_a | input | 12 | Channel A sample, two's complement |
| adc_b | input | 12 | Channel B sample, two's complement |
| trig_pin_i | input | 2 | External trigger pins, as read |
| trig_pin_o | output | 2 | Trigger pin drive value |
| trig_pin_oe | output | 2 | Trigger pin drive enable |
| out_valid | output | 1 | Tagged word pair valid |
| out_a | output | 16 | Channel A tagged word |
| out_b | output | 16 | Channel B tagged word |

## Verification
The analog and pin hits of a channel meet in the same cycle when the source select combines them, so the bench holds a pin at a chosen level or leaves an edge pending and then presents a sample above or below the limit, judging the AND and OR results against a reference model of both rules. A pin edge that arrives between samples must also land in the same word as a later analog crossing; the bench raises a pin several clocks before a crossing sample and checks that both bits 13 and 12 and the combined flag appear on that one word. Crossing history and armed state advance only on valid samples, which the model tracks across configuration changes.

// File: rtl/atg_pkg.sv
package atg_pkg;
  localparam int SMP_W   = 12;
  localparam int WORD_W  = 16;
  localparam int N_CH    = 2;
  localparam int ADDR_W  = 2;
  localparam int MODE_W  = 3;
  localparam int CTRL_W  = 2 + 2 + 2 * MODE_W;
  localparam int LVL_W   = 2 * SMP_W;
  localparam int CFG_W   = LVL_W;
  localparam int WIDE_W  = SMP_W + 2;

  // pin trigger modes
  localparam logic [MODE_W-1:0] PM_HIGH = 3'd0;
  localparam logic [MODE_W-1:0] PM_LOW  = 3'd1;
  localparam logic [MODE_W-1:0] PM_ANY  = 3'd2;
  localparam logic [MODE_W-1:0] PM_RISE = 3'd3;
  localparam logic [MODE_W-1:0] PM_FALL = 3'd4;

  // analog trigger modes
  localparam logic [MODE_W-1:0] AM_ABOVE = 3'd0;
  localparam logic [MODE_W-1:0] AM_BELOW = 3'd1;
  localparam logic [MODE_W-1:0] AM_CROSS = 3'd2;
  localparam logic [MODE_W-1:0] AM_UP    = 3'd3;
  localparam logic [MODE_W-1:0] AM_DOWN  = 3'd4;

  typedef enum logic [1:0] {
    SRC_ANALOG = 2'd0,
    SRC_PIN    = 2'd1,
    SRC_AND    = 2'd2,
    SRC_OR     = 2'd3
  } src_sel_e;

  typedef struct packed {
    logic              drv_val;
    logic              drv_en;
    logic [1:0]        src;
    logic [MODE_W-1:0] amode;
    logic [MODE_W-1:0] pmode;
  } ctrl_t;

  typedef struct packed {
    logic [SMP_W-1:0] hyst;
    logic [SMP_W-1:0] limit;
  } lvl_t;

  localparam logic [CTRL_W-1:0] CTRL_RST = 10'h03F;
  localparam logic [LVL_W-1:0]  LVL_RST  = '0;
endpackage

// File: rtl/atg_cfg_cdc.sv
module atg_cfg_cdc #(
  parameter int              W       = 8,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         src_clk,
  input  logic         src_rst_n,
  input  logic         src_load,
  input  logic [W-1:0] src_data,
  input  logic         dst_clk,
  input  logic         dst_rst_n,
  output logic [W-1:0] dst_q
);
  logic [W-1:0] hold_q, hold_d;
  logic         tog_q, tog_d;
  logic         s1_q, s2_q, s3_q;
  logic [W-1:0] shadow_q, shadow_d;
  logic         take;

  always_comb begin
    hold_d = hold_q;
    tog_d  = tog_q;
    if (src_load) begin
      hold_d = src_data;
      tog_d  = ~tog_q;
    end
  end

  always_ff @(posedge src_clk or negedge src_rst_n) begin
    if (!src_rst_n) begin
      hold_q <= RST_VAL;
      tog_q  <= 1'b0;
    end else begin
      hold_q <= hold_d;
      tog_q  <= tog_d;
    end
  end

  assign take     = s2_q ^ s3_q;
  assign shadow_d = take ? hold_q : shadow_q;

  always_ff @(posedge dst_clk or negedge dst_rst_n) begin
    if (!dst_rst_n) begin
      s1_q     <= 1'b0;
      s2_q     <= 1'b0;
      s3_q     <= 1'b0;
      shadow_q <= RST_VAL;
    end else begin
      s1_q     <= tog_q;
      s2_q     <= s1_q;
      s3_q     <= s2_q;
      shadow_q <= shadow_d;
    end
  end

  assign dst_q = shadow_q;
endmodule

// File: rtl/atg_pin_eval.sv
module atg_pin_eval
  import atg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pin_i,
  input  logic              smp_valid,
  input  logic [MODE_W-1:0] mode,
  output logic              hit
);
  logic sync1_q, sync2_q, last_q;
  logic rise_st_q, rise_st_d, fall_st_q, fall_st_d;
  logic rise_now, fall_now, rise_any, fall_any;

  assign rise_now = sync2_q & ~last_q;
  assign fall_now = ~sync2_q & last_q;
  assign rise_any = rise_now | rise_st_q;
  assign fall_any = fall_now | fall_st_q;

  always_comb begin
    rise_st_d = smp_valid ? 1'b0 : rise_any;
    fall_st_d = smp_valid ? 1'b0 : fall_any;
  end

  always_comb begin
    unique case (mode)
      PM_HIGH: hit = sync2_q;
      PM_LOW:  hit = ~sync2_q;
      PM_ANY:  hit = rise_any | fall_any;
      PM_RISE: hit = rise_any;
      PM_FALL: hit = fall_any;
      default: hit = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q   <= 1'b0;
      sync2_q   <= 1'b0;
      last_q    <= 1'b0;
      rise_st_q <= 1'b0;
      fall_st_q <= 1'b0;
    end else begin
      sync1_q   <= pin_i;
      sync2_q   <= sync1_q;
      last_q    <= sync2_q;
      rise_st_q <= rise_st_d;
      fall_st_q <= fall_st_d;
    end
  end
endmodule

// File: rtl/atg_level_eval.sv
module atg_level_eval
  import atg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_valid,
  input  logic [SMP_W-1:0]  smp,
  input  logic [SMP_W-1:0]  limit,
  input  logic [SMP_W-1:0]  hyst,
  input  logic [MODE_W-1:0] mode,
  output logic              hit
);
  logic signed [WIDE_W-1:0] cur_w, prev_w, lim_w, lo_w, hi_w;
  logic [SMP_W-1:0]         prev_q, prev_d;
  logic                     arm_up_q, arm_up_d, arm_dn_q, arm_dn_d;
  logic                     up_x, dn_x;

  assign cur_w  = WIDE_W'($signed(smp));
  assign prev_w = WIDE_W'($signed(prev_q));
  assign lim_w  = WIDE_W'($signed(limit));
  assign lo_w   = lim_w - $signed({2'b00, hyst});
  assign hi_w   = lim_w + $signed({2'b00, hyst});

  assign up_x = arm_up_q & (prev_w <= lim_w) & (cur_w > lim_w);
  assign dn_x = arm_dn_q & (prev_w >= lim_w) & (cur_w < lim_w);

  always_comb begin
    unique case (mode)
      AM_ABOVE: hit = cur_w > lim_w;
      AM_BELOW: hit = cur_w < lim_w;
      AM_CROSS: hit = up_x | dn_x;
      AM_UP:    hit = up_x;
      AM_DOWN:  hit = dn_x;
      default:  hit = 1'b0;
    endcase
  end

  always_comb begin
    prev_d   = prev_q;
    arm_up_d = arm_up_q;
    arm_dn_d = arm_dn_q;
    if (smp_valid) begin
      prev_d   = smp;
      arm_up_d = (cur_w <= lo_w) | (arm_up_q & ~up_x);
      arm_dn_d = (cur_w >= hi_w) | (arm_dn_q & ~dn_x);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q   <= '0;
      arm_up_q <= 1'b1;
      arm_dn_q <= 1'b1;
    end else begin
      prev_q   <= prev_d;
      arm_up_q <= arm_up_d;
      arm_dn_q <= arm_dn_d;
    end
  end
endmodule

// File: rtl/adc_trig_tagger.sv
module adc_trig_tagger
  import atg_pkg::*;
(
  input  logic              cfg_clk,
  input  logic              cfg_rst_n,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [CFG_W-1:0]  cfg_wdata,
  input  logic              adc_clk,
  input  logic              adc_rst_n,
  input  logic              adc_valid,
  input  logic [SMP_W-1:0]  adc_a,
  input  logic [SMP_W-1:0]  adc_b,
  input  logic [N_CH-1:0]   trig_pin_i,
  output logic [N_CH-1:0]   trig_pin_o,
  output logic [N_CH-1:0]   trig_pin_oe,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_a,
  output logic [WORD_W-1:0] out_b
);
  logic [CTRL_W-1:0] ctrl_raw [N_CH];
  logic [LVL_W-1:0]  lvl_raw  [N_CH];
  logic [SMP_W-1:0]  smp_in   [N_CH];
  logic [N_CH-1:0]   a_hit, p_hit, flag;
  logic [WORD_W-1:0] word_d [N_CH];
  logic [WORD_W-1:0] word_q [N_CH];
  logic              valid_q;

  assign smp_in[0] = adc_a;
  assign smp_in[1] = adc_b;

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    ctrl_t ctl;
    lvl_t  lvl;

    atg_cfg_cdc #(.W(CTRL_W), .RST_VAL(CTRL_RST)) u_ctrl_cdc (
      .src_clk  (cfg_clk),
      .src_rst_n(cfg_rst_n),
      .src_load (cfg_we && (cfg_addr == ADDR_W'(c))),
      .src_data (cfg_wdata[CTRL_W-1:0]),
      .dst_clk  (adc_clk),
      .dst_rst_n(adc_rst_n),
      .dst_q    (ctrl_raw[c])
    );

    atg_cfg_cdc #(.W(LVL_W), .RST_VAL(LVL_RST)) u_lvl_cdc (
      .src_clk  (cfg_clk),
      .src_rst_n(cfg_rst_n),
      .src_load (cfg_we && (cfg_addr == ADDR_W'(N_CH + c))),
      .src_data (cfg_wdata[LVL_W-1:0]),
      .dst_clk  (adc_clk),
      .dst_rst_n(adc_rst_n),
      .dst_q    (lvl_raw[c])
    );

    assign ctl = ctrl_t'(ctrl_raw[c]);
    assign lvl = lvl_t'(lvl_raw[c]);

    atg_level_eval u_level (
      .clk      (adc_clk),
      .rst_n    (adc_rst_n),
      .smp_valid(adc_valid),
      .smp      (smp_in[c]),
      .limit    (lvl.limit),
      .hyst     (lvl.hyst),
      .mode     (ctl.amode),
      .hit      (a_hit[c])
    );

    atg_pin_eval u_pin (
      .clk      (adc_clk),
      .rst_n    (adc_rst_n),
      .pin_i    (trig_pin_i[c]),
      .smp_valid(adc_valid),
      .mode     (ctl.pmode),
      .hit      (p_hit[c])
    );

    always_comb begin
      unique case (src_sel_e'(ctl.src))
        SRC_ANALOG: flag[c] = a_hit[c];
        SRC_PIN:    flag[c] = p_hit[c];
        SRC_AND:    flag[c] = a_hit[c] & p_hit[c];
        SRC_OR:     flag[c] = a_hit[c] | p_hit[c];
        default:    flag[c] = 1'b0;
      endcase
    end

    assign trig_pin_o[c]  = ctl.drv_val;
    assign trig_pin_oe[c] = ctl.drv_en;
  end

  for (genvar c = 0; c < N_CH; c++) begin : g_word
    always_comb begin
      word_d[c] = '0;
      if (adc_valid) begin
        word_d[c][SMP_W-1:0] = smp_in[c];
        word_d[c][SMP_W]     = p_hit[c];
        word_d[c][SMP_W+1]   = a_hit[c];
        for (int k = 0; k < N_CH; k++) begin
          word_d[c][WORD_W-1-k] = flag[k];
        end
      end
    end

    always_ff @(posedge adc_clk or negedge adc_rst_n) begin
      if (!adc_rst_n) word_q[c] <= '0;
      else            word_q[c] <= word_d[c];
    end
  end

  always_ff @(posedge adc_clk or negedge adc_rst_n) begin
    if (!adc_rst_n) valid_q <= 1'b0;
    else            valid_q <= adc_valid;
  end

  assign out_valid = valid_q;
  assign out_a     = word_q[0];
  assign out_b     = word_q[1];
endmodule

// File: rtl/atg_checker.sv
module atg_checker
  import atg_pkg::*;
(
  input logic              adc_clk,
  input logic              adc_rst_n,
  input logic              adc_valid,
  input logic [SMP_W-1:0]  adc_a,
  input logic [SMP_W-1:0]  adc_b,
  input logic [N_CH-1:0]   trig_pin_oe,
  input logic              out_valid,
  input logic [WORD_W-1:0] out_a,
  input logic [WORD_W-1:0] out_b
);
  always @(posedge adc_clk) begin
    if (!adc_rst_n) begin
      p_reset_quiet_r1: assert (!out_valid && out_a == '0 && out_b == '0 && trig_pin_oe == '0)
        else $error("reset state violated");
    end
  end

  p_sample_passes_r2: assert property (@(posedge adc_clk) disable iff (!adc_rst_n)
    adc_valid |=> out_valid && out_a[SMP_W-1:0] == $past(adc_a) && out_b[SMP_W-1:0] == $past(adc_b));

  p_no_valid_no_out_r2: assert property (@(posedge adc_clk) disable iff (!adc_rst_n)
    !adc_valid |=> !out_valid);

  p_idle_words_zero_r12: assert property (@(posedge adc_clk) disable iff (!adc_rst_n)
    !out_valid |-> (out_a == '0 && out_b == '0));

  p_flags_shared_r8: assert property (@(posedge adc_clk) disable iff (!adc_rst_n)
    out_valid |-> out_a[WORD_W-1 -: N_CH] == out_b[WORD_W-1 -: N_CH]);

  p_a_flag_needs_source_r8: assert property (@(posedge adc_clk) disable iff (!adc_rst_n)
    (out_valid && !out_a[SMP_W+1] && !out_a[SMP_W]) |-> !out_a[WORD_W-1]);

  p_b_flag_needs_source_r8: assert property (@(posedge adc_clk) disable iff (!adc_rst_n)
    (out_valid && !out_b[SMP_W+1] && !out_b[SMP_W]) |-> !out_b[WORD_W-2]);
endmodule

bind adc_trig_tagger atg_checker chk_i (
  .adc_clk    (adc_clk),
  .adc_rst_n  (adc_rst_n),
  .adc_valid  (adc_valid),
  .adc_a      (adc_a),
  .adc_b      (adc_b),
  .trig_pin_oe(trig_pin_oe),
  .out_valid  (out_valid),
  .out_a      (out_a),
  .out_b      (out_b)
);

// File: tb/adc_trig_tagger_tb_top.sv
`timescale 1ns/1ps
module adc_trig_tagger_tb_top;
  logic        cfg_clk = 1'b0, adc_clk = 1'b0;
  logic        cfg_rst_n = 1'b0, adc_rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_addr = '0;
  logic [23:0] cfg_wdata = '0;
  logic        adc_valid = 1'b0;
  logic [11:0] adc_a = '0, adc_b = '0;
  logic [1:0]  trig_pin_i = '0;
  logic [1:0]  trig_pin_o, trig_pin_oe;
  logic        out_valid;
  logic [15:0] out_a, out_b;

  always #5 adc_clk = ~adc_clk;
  always #7 cfg_clk = ~cfg_clk;

  adc_trig_tagger dut_i (.*);

  typedef struct { logic [15:0] a; logic [15:0] b; string tag; } item_t;
  item_t exp_q[$];
  int n_chk = 0, n_fail = 0;
  bit run = 1'b0;

  // reference model state
  int m_prev[2], m_lim[2], m_hys[2];
  bit m_aup[2], m_adn[2], m_pin[2], m_rise[2], m_fall[2];
  int m_pmode[2], m_amode[2], m_src[2];

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int sx12(int v);
    return (v & 32'h800) != 0 ? (v & 32'hFFF) - 4096 : (v & 32'hFFF);
  endfunction

  function automatic void model_ch(int c, int s, output bit ah, output bit ph);
    bit up, dn;
    up = m_aup[c] && m_prev[c] <= m_lim[c] && s > m_lim[c];
    dn = m_adn[c] && m_prev[c] >= m_lim[c] && s < m_lim[c];
    case (m_amode[c])
      0: ah = s > m_lim[c];
      1: ah = s < m_lim[c];
      2: ah = up || dn;
      3: ah = up;
      4: ah = dn;
      default: ah = 1'b0;
    endcase
    case (m_pmode[c])
      0: ph = m_pin[c];
      1: ph = !m_pin[c];
      2: ph = m_rise[c] || m_fall[c];
      3: ph = m_rise[c];
      4: ph = m_fall[c];
      default: ph = 1'b0;
    endcase
    m_aup[c]  = (s <= m_lim[c] - m_hys[c]) || (m_aup[c] && !up);
    m_adn[c]  = (s >= m_lim[c] + m_hys[c]) || (m_adn[c] && !dn);
    m_prev[c] = s;
    m_rise[c] = 1'b0;
    m_fall[c] = 1'b0;
  endfunction

  function automatic bit combine(int c, bit ah, bit ph);
    case (m_src[c])
      0: return ah;
      1: return ph;
      2: return ah && ph;
      default: return ah || ph;
    endcase
  endfunction

  task automatic send(int sa, int sb, string tag);
    bit ah0, ph0, ah1, ph1, f0, f1;
    item_t it;
    model_ch(0, sa, ah0, ph0);
    model_ch(1, sb, ah1, ph1);
    f0 = combine(0, ah0, ph0);
    f1 = combine(1, ah1, ph1);
    it.a = {f0, f1, ah0, ph0, sa[11:0]};
    it.b = {f0, f1, ah1, ph1, sb[11:0]};
    it.tag = tag;
    @(negedge adc_clk);
    exp_q.push_back(it);
    adc_valid = 1'b1;
    adc_a = sa[11:0];
    adc_b = sb[11:0];
    @(negedge adc_clk);
    adc_valid = 1'b0;
  endtask

  task automatic cfg_write(int addr, int data);
    @(negedge cfg_clk);
    cfg_we = 1'b1;
    cfg_addr = addr[1:0];
    cfg_wdata = data[23:0];
    @(negedge cfg_clk);
    cfg_we = 1'b0;
    repeat (8) @(negedge adc_clk);
    if (addr < 2) begin
      m_pmode[addr] = data & 7;
      m_amode[addr] = (data >> 3) & 7;
      m_src[addr]   = (data >> 6) & 3;
    end else begin
      m_lim[addr-2] = sx12(data & 32'hFFF);
      m_hys[addr-2] = (data >> 12) & 32'hFFF;
    end
  endtask

  function automatic int ctrl(int pm, int am, int src, int en, int val);
    return pm | (am << 3) | (src << 6) | (en << 8) | (val << 9);
  endfunction

  function automatic int lvl(int lim, int hys);
    return (lim & 32'hFFF) | ((hys & 32'hFFF) << 12);
  endfunction

  task automatic set_pin(int c, bit v);
    @(negedge adc_clk);
    if (v && !m_pin[c]) m_rise[c] = 1'b1;
    if (!v && m_pin[c]) m_fall[c] = 1'b1;
    m_pin[c] = v;
    trig_pin_i[c] = v;
    repeat (5) @(negedge adc_clk);
  endtask

  // scoreboard monitor
  always @(negedge adc_clk) begin
    if (run) begin
      if (out_valid) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R2 unexpected word", {out_a, out_b}, 32'h0);
        end else begin
          item_t e;
          e = exp_q.pop_front();
          chk({out_a, out_b} == {e.a, e.b}, e.tag, {out_a, out_b}, {e.a, e.b});
        end
      end else begin
        chk({out_a, out_b} == 32'h0, "R12 idle words", {out_a, out_b}, 32'h0);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge adc_clk);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    for (int c = 0; c < 2; c++) begin
      m_prev[c] = 0; m_lim[c] = 0; m_hys[c] = 0;
      m_aup[c] = 1'b1; m_adn[c] = 1'b1; m_pin[c] = 1'b0;
      m_rise[c] = 1'b0; m_fall[c] = 1'b0;
      m_pmode[c] = 7; m_amode[c] = 7; m_src[c] = 0;
    end
    repeat (3) @(negedge adc_clk);
    chk(!out_valid && out_a == 0 && out_b == 0 && trig_pin_oe == 0, "R1 reset outputs",
        {out_valid, trig_pin_oe, out_a[12:0]}, 32'h0);
    cfg_rst_n = 1'b1;
    adc_rst_n = 1'b1;
    repeat (2) @(negedge adc_clk);
    run = 1'b1;

    // R9: reset configuration never triggers
    send(100, -100, "R9 reset config");
    send(-2048, 2047, "R9 reset config extremes");

    // R3: level comparisons, signed
    cfg_write(0, ctrl(7, 0, 0, 0, 0));
    cfg_write(1, ctrl(7, 1, 0, 0, 0));
    cfg_write(2, lvl(100, 0));
    cfg_write(3, lvl(-50, 0));
    send(101, -51, "R3 above/below hit");
    send(100, -50, "R3 equal no hit");
    send(-2048, 2047, "R3 signed extremes");
    send(2047, -2048, "R2 R3 full scale");

    // R10: level change takes effect whole
    cfg_write(2, lvl(-2048, 0));
    send(-2047, -49, "R10 new limit");

    // R4 R5: crossings with hysteresis
    cfg_write(0, ctrl(7, 3, 0, 0, 0));
    cfg_write(2, lvl(0, 10));
    cfg_write(1, ctrl(7, 4, 0, 0, 0));
    cfg_write(3, lvl(0, 0));
    send(-5, 5, "R4 setup");
    send(3, -1, "R4 up/down cross");
    send(-3, 5, "R5 rebound");
    send(4, -1, "R5 up blocked, down rearmed");
    send(-10, 0, "R5 arm at limit minus hyst");
    send(1, -1, "R5 up accepted again");
    cfg_write(0, ctrl(7, 2, 0, 0, 0));
    cfg_write(2, lvl(0, 0));
    send(-7, 3, "R4 any cross down");
    send(7, 3, "R4 any cross up");
    send(7, -3, "R4 no cross when staying");

    // R6 R7: pin modes
    cfg_write(0, ctrl(3, 7, 1, 0, 0));
    cfg_write(1, ctrl(0, 7, 1, 0, 0));
    set_pin(0, 1'b1);
    send(1, 1, "R6 rise edge pending, R7 pin0 to A");
    send(1, 1, "R6 rise consumed");
    set_pin(1, 1'b1);
    send(2, 2, "R7 pin1 level to B");
    cfg_write(0, ctrl(4, 7, 1, 0, 0));
    cfg_write(1, ctrl(1, 7, 1, 0, 0));
    set_pin(0, 1'b0);
    send(3, 3, "R6 fall and low");
    cfg_write(0, ctrl(2, 7, 1, 0, 0));
    set_pin(0, 1'b1);
    send(4, 4, "R6 any edge");
    cfg_write(0, ctrl(1, 7, 1, 0, 0));
    send(4, 4, "R6 low mode pin high");

    // R8: combining sources
    cfg_write(0, ctrl(0, 0, 2, 0, 0));
    cfg_write(1, ctrl(0, 0, 3, 0, 0));
    cfg_write(3, lvl(0, 0));
    send(5, -5, "R8 AND both, OR pin only");
    send(-5, 5, "R8 AND pin only");
    set_pin(0, 1'b0);
    set_pin(1, 1'b0);
    send(5, -5, "R8 AND analog only, OR none");
    send(-5, 5, "R8 OR analog only");
    cfg_write(0, ctrl(3, 3, 3, 0, 0));
    cfg_write(1, ctrl(3, 3, 2, 0, 0));
    send(-5, -5, "R8 setup below");
    set_pin(0, 1'b1);
    set_pin(1, 1'b1);
    send(6, 6, "R8 edge and crossing same word");

    // R9: unused codes
    cfg_write(0, ctrl(5, 6, 3, 0, 0));
    cfg_write(1, ctrl(6, 5, 3, 0, 0));
    send(-100, 100, "R9 unused mode codes");

    // R11: pin drive
    cfg_write(0, ctrl(7, 7, 0, 1, 1));
    cfg_write(1, ctrl(7, 7, 0, 1, 0));
    @(negedge adc_clk);
    chk(trig_pin_oe == 2'b11 && trig_pin_o == 2'b01, "R11 pin drive", {trig_pin_oe, trig_pin_o}, 4'b1101);
    cfg_write(0, ctrl(7, 7, 0, 0, 1));
    @(negedge adc_clk);
    chk(trig_pin_oe == 2'b10, "R11 drive enable off", trig_pin_oe, 2'b10);

    repeat (4) @(negedge adc_clk);
    chk(exp_q.size() == 0, "R2 all words seen", exp_q.size(), 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule